// File: doc/BRIEF.md
# Mantissa-Exponent Oversampling Tick Generator

This block produces the 16x oversampling tick for a serial channel. The reference clock is qualified by a clock enable. The tick is one pulse every (N+1)·2^M enabled reference cycles. N is a 6-bit mantissa and M is a 4-bit exponent. The two are packed into two 8-bit registers written over a simple write port. The serial bit rate is therefore the reference rate divided by 16·(N+1)·2^M. Software picks N and M; this block only applies them.

Two more options sit in the configuration register. A scaling-enable bit bypasses the generator when it is clear, so every enabled reference cycle produces a tick. A divide-by-four option thins the reference enable to one in four before the generator sees it. Any register write restarts the whole chain, so the first period after a write already uses the new values.

Top module: `baud_tick_gen`

## Requirements
- R1: While `rst_n` is low, `tick` is 0 on the following cycle. Reset clears every register field, which leaves the block in bypass mode without the divide-by-four option.
- R2: With scaling enabled, the predivider off and no writes, `tick` is high for one cycle after every (N+1)·2^M-th enabled cycle, counted from the last restart.
- R3: A write with `wr_sel`=0 (divisor register) loads N from `wr_data[5:0]` and the low two bits of M from `wr_data[7:6]`. The high bits of M are left as they are.
- R4: A write with `wr_sel`=1 (configuration register) loads the high two bits of M from `wr_data[7:6]`. It leaves N and the low bits of M unchanged, so M spans 0 to 15.
- R5: When the scaling-enable bit (`wr_data[5]` of the configuration register) is 0, the division factor is 1 whatever N and M hold.
- R6: When the predivide bit (`wr_data[4]` of the configuration register) is 1, the tick period is four times longer. This also applies in bypass mode, where a tick follows every fourth enabled cycle.
- R7: A cycle with `clk_en` low does not advance any count, and `tick` is high only in the cycle after an enabled cycle.
- R8: Any write restarts all counts, and `tick` is 0 in the cycle after the write. The next tick follows a full period under the new values.
- R9: Two consecutive ticks can occur only when the total division factor is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous reset, active low |
| clk_en | input | 1 | Reference clock enable; only enabled cycles are counted |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Register select: 0 divisor, 1 configuration |
| wr_data | input | 8 | Register write data |
| tick | output | 1 | One-cycle oversampling tick |

## Verification
A wrong count limit in the prescaler or mantissa stage moves the first tick after a restart by at least one enabled cycle. A missed or wrong restart shows within one period as a tick at an unexpected cycle. A swapped exponent field scales the period by a power of two and is visible at the first tick. The bench compares `tick` against its own period model on every cycle, across N and M extremes, gapped enables, mid-period rewrites and both option bits, so each such error shows as a mismatch on that exact cycle.

// File: rtl/baud_pkg.sv
// Package: widths, register field positions and the decoded divisor
// configuration shared by the tick generator and its sub-blocks.
package baud_pkg;
    localparam int DATA_W    = 8;   // register write width
    localparam int N_W       = 6;   // mantissa width
    localparam int M_W       = 4;   // exponent width
    localparam int M_LO_W    = 2;   // exponent bits held in the divisor register
    localparam int M_HI_W    = M_W - M_LO_W;
    localparam int SCALE_BIT = 5;   // configuration: scaling enable
    localparam int PRE_BIT   = 4;   // configuration: divide-by-four
    localparam int PRE_RATIO = 4;   // predivider ratio

    localparam logic SEL_DIV = 1'b0;
    localparam logic SEL_CFG = 1'b1;

    typedef struct packed {
        logic [N_W-1:0] n_val;
        logic [M_W-1:0] m_exp;
        logic           scale_en;
        logic           pre_en;
    } div_cfg_t;
endpackage

// File: rtl/baud_regs.sv
// Register holder: splits writes to the divisor and configuration
// registers into the decoded divisor fields. Assumes single-cycle writes.
module baud_regs
    import baud_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    output div_cfg_t          cfg
);
    // Capture register writes into the decoded field set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '0;
        end else if (wr_en) begin
            if (wr_sel == SEL_DIV) begin
                cfg.n_val              <= wr_data[N_W-1:0];
                cfg.m_exp[M_LO_W-1:0]  <= wr_data[DATA_W-1 -: M_LO_W];
            end else begin
                cfg.m_exp[M_W-1:M_LO_W] <= wr_data[DATA_W-1 -: M_HI_W];
                cfg.scale_en            <= wr_data[SCALE_BIT];
                cfg.pre_en              <= wr_data[PRE_BIT];
            end
        end
    end
endmodule

// File: rtl/baud_prediv.sv
// Optional fixed predivider: when enabled, passes one of every RATIO
// input steps; when disabled, passes every step. Restart clears the phase.
module baud_prediv #(
    parameter int RATIO = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic enable,
    input  logic step_in,
    output logic step_out
);
    localparam int W = (RATIO > 1) ? $clog2(RATIO) : 1;
    localparam logic [W-1:0] LAST = W'(RATIO - 1);

    logic [W-1:0] phase;

    // Select between the thinned and the unthinned step.
    assign step_out = enable ? (step_in && (phase == LAST)) : step_in;

    // Advance the phase on each input step while enabled.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            phase <= '0;
        end else if (enable && step_in) begin
            phase <= (phase == LAST) ? '0 : phase + W'(1);
        end
    end
endmodule

// File: rtl/baud_prescale.sv
// Exponent prescaler: passes one of every 2^m_exp input steps.
// The terminal count is a thermometer mask built from m_exp.
module baud_prescale #(
    parameter int M_W = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           restart,
    input  logic           active,
    input  logic [M_W-1:0] m_exp,
    input  logic           step_in,
    output logic           step_out
);
    localparam int CW = (1 << M_W) - 1;

    logic [CW-1:0] count;
    logic [CW-1:0] limit;

    // Build 2^m_exp - 1 as a low-order run of ones.
    always_comb begin
        for (int i = 0; i < CW; i++) begin
            limit[i] = (i < int'(m_exp));
        end
    end

    // Emit a step when the count sits at its limit.
    assign step_out = step_in && (count == limit);

    // Count input steps, wrapping at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            count <= '0;
        end else if (active && step_in) begin
            count <= (count == limit) ? '0 : count + CW'(1);
        end
    end
endmodule

// File: rtl/baud_mant.sv
// Mantissa counter: flags done on every (n_val+1)-th input step.
module baud_mant #(
    parameter int N_W = 6
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           restart,
    input  logic           active,
    input  logic [N_W-1:0] n_val,
    input  logic           step_in,
    output logic           done
);
    logic [N_W-1:0] count;

    // Done on the step that reaches the mantissa value.
    assign done = step_in && (count == n_val);

    // Count prescaled steps, wrapping at the mantissa value.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            count <= '0;
        end else if (active && step_in) begin
            count <= (count == n_val) ? '0 : count + N_W'(1);
        end
    end
endmodule

// File: rtl/baud_tick_gen.sv
// Top: oversampling tick generator dividing the enabled reference clock by
// (N+1)*2^M, optionally by four more, or bypassed to factor 1. Any register
// write restarts every stage. Tick is registered, one cycle wide.
module baud_tick_gen
    import baud_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_en,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    output logic              tick
);
    div_cfg_t       cfg;
    logic [N_W-1:0] cfg_n;
    logic [M_W-1:0] cfg_m;
    logic           cfg_scale;
    logic           cfg_pre;
    logic           pre_step;
    logic           exp_step;
    logic           mant_done;
    logic           tick_next;

    assign cfg_n     = cfg.n_val;
    assign cfg_m     = cfg.m_exp;
    assign cfg_scale = cfg.scale_en;
    assign cfg_pre   = cfg.pre_en;

    baud_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .cfg     (cfg)
    );

    baud_prediv #(.RATIO(PRE_RATIO)) u_prediv (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (wr_en),
        .enable   (cfg_pre),
        .step_in  (clk_en),
        .step_out (pre_step)
    );

    baud_prescale #(.M_W(M_W)) u_prescale (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (wr_en),
        .active   (cfg_scale),
        .m_exp    (cfg_m),
        .step_in  (pre_step),
        .step_out (exp_step)
    );

    baud_mant #(.N_W(N_W)) u_mant (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (wr_en),
        .active  (cfg_scale),
        .n_val   (cfg_n),
        .step_in (exp_step),
        .done    (mant_done)
    );

    // Bypass selects the predivided step directly.
    assign tick_next = cfg_scale ? mant_done : pre_step;

    // Register the tick; writes and reset suppress it.
    always_ff @(posedge clk) begin
        if (!rst_n || wr_en) begin
            tick <= 1'b0;
        end else begin
            tick <= tick_next;
        end
    end
endmodule

// File: rtl/baud_tick_gen_chk.sv
// Checker: temporal properties of the tick generator, bound to the top.
module baud_tick_gen_chk
    import baud_pkg::*;
(
    input logic           clk,
    input logic           rst_n,
    input logic           clk_en,
    input logic           wr_en,
    input logic           tick,
    input logic [N_W-1:0] cfg_n,
    input logic [M_W-1:0] cfg_m,
    input logic           cfg_scale,
    input logic           cfg_pre
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk) !rst_n |=> !tick);

    // R7
    tick_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> $past(clk_en));

    // R8
    write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !tick);

    // R5
    bypass_each_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && !wr_en && !cfg_scale && !cfg_pre) |=> tick);

    // R9
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && $past(tick)) |->
        (!cfg_pre && (!cfg_scale || (cfg_n == '0 && cfg_m == '0))));
endmodule

bind baud_tick_gen baud_tick_gen_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .clk_en    (clk_en),
    .wr_en     (wr_en),
    .tick      (tick),
    .cfg_n     (cfg_n),
    .cfg_m     (cfg_m),
    .cfg_scale (cfg_scale),
    .cfg_pre   (cfg_pre)
);

// File: tb/tb_baud_tick_gen.sv
`timescale 1ns/1ps
// Bench: behavioural period model compared with the tick on every cycle.
module tb_baud_tick_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clk_en = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_sel = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       tick;

    int    checks = 0;
    int    failures = 0;
    bit    checking = 1'b0;
    bit    done = 1'b0;
    string cur_req = "R1";

    // Model state, taken from the requirements only.
    int m_n = 0, m_m = 0, m_cnt = 0;
    bit m_scale = 0, m_pre = 0, exp_tick = 0;

    baud_tick_gen dut (
        .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_data(wr_data), .tick(tick)
    );

    always #2 clk = ~clk;

    function automatic int period();
        int p;
        p = m_scale ? (m_n + 1) * (1 << m_m) : 1;
        return m_pre ? p * 4 : p;
    endfunction

    // Reference model: counts enabled cycles since the last restart.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_n = 0; m_m = 0; m_scale = 0; m_pre = 0; m_cnt = 0; exp_tick = 0;
        end else if (wr_en) begin
            if (wr_sel == 1'b0) begin
                m_n = int'(wr_data[5:0]);
                m_m = (m_m & 12) | int'(wr_data[7:6]);
            end else begin
                m_m = (m_m & 3) | (int'(wr_data[7:6]) << 2);
                m_scale = wr_data[5];
                m_pre = wr_data[4];
            end
            m_cnt = 0; exp_tick = 0;
        end else if (clk_en) begin
            m_cnt++;
            if (m_cnt >= period()) begin
                exp_tick = 1; m_cnt = 0;
            end else begin
                exp_tick = 0;
            end
        end else begin
            exp_tick = 0;
        end
        checking = 1'b1;
    end

    // Compare away from the active edge.
    always @(negedge clk) begin
        if (checking && !done) begin
            checks++;
            if (tick !== exp_tick) begin
                failures++;
                $display("FAIL %s t=%0t tick actual=%b expected=%b", cur_req, $time, tick, exp_tick);
            end
        end
    end

    task automatic wreg(input bit sel, input logic [7:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_data = d; clk_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic run(input int n, input int gap);
        for (int i = 0; i < n; i++) begin
            clk_en = (gap == 0) ? 1'b1 : ((i % gap) != gap - 1);
            @(negedge clk);
        end
    endtask

    initial begin
        cur_req = "R1";
        @(negedge clk); clk_en = 1'b1;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        cur_req = "R5"; run(10, 0);                 // reset leaves bypass
        cur_req = "R2"; wreg(1'b1, 8'h20); wreg(1'b0, 8'h02); run(30, 0);   // factor 3
        cur_req = "R3"; wreg(1'b0, 8'hC0); run(40, 0);                      // M=3, 8
        cur_req = "R3"; wreg(1'b0, 8'h3F); run(200, 0);                     // N=63, 64
        cur_req = "R4"; wreg(1'b0, 8'hC0); wreg(1'b1, 8'h60); run(400, 0);  // M=7
        cur_req = "R4"; wreg(1'b1, 8'hA0); wreg(1'b0, 8'h41); run(9000, 0); // M=9, N=1
        cur_req = "R6"; wreg(1'b1, 8'h30); wreg(1'b0, 8'h41); run(80, 0);   // 16
        cur_req = "R6"; wreg(1'b1, 8'h10); run(40, 0);                      // bypass /4
        cur_req = "R5"; wreg(1'b0, 8'hFF); wreg(1'b1, 8'h00); run(20, 0);   // N,M ignored
        cur_req = "R7"; wreg(1'b0, 8'h04); wreg(1'b1, 8'h20); run(90, 3);   // 5, gapped
        cur_req = "R7"; run(60, 2);
        cur_req = "R8"; run(3, 0); wreg(1'b0, 8'h04); run(3, 0);
        wreg(1'b0, 8'h03); wreg(1'b0, 8'h03); run(20, 0);
        cur_req = "R9"; wreg(1'b0, 8'h00); run(10, 0); wreg(1'b0, 8'h01); run(10, 0);
        cur_req = "R2"; wreg(1'b1, 8'hE0); wreg(1'b0, 8'hC0); run(66000, 0); // M=15
        cur_req = "R1"; rst_n = 1'b0; run(3, 0); rst_n = 1'b1;
        cur_req = "R5"; run(5, 0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule